// File: doc/BRIEF.md
# Mailbox Receive Engine for a Network Tile

This block connects the local delivery port of an on-chip router to a processor that collects incoming messages through a small register mailbox. The router hands over flits with no regard for whether the processor is ready. The engine therefore sorts each flit by its source tile into a private input queue, and never pushes back on the router.

The processor sets up a message in three steps. It selects the source tile, gives the shared-memory address for the first word, and writes the word count, which starts the transfer. After that it paces the transfer one word at a time with a four-phase ACK/RDY handshake:

- The processor lowers ACK.
- The engine writes one word into shared memory and raises RDY.
- The processor reads the word and raises ACK.
- The engine drops RDY, which closes the cycle.

After the last word the engine pulses a done strobe and goes back to idle.

Top module: `mbox_rx_engine`

## Requirements
- R1: After a synchronous reset the outputs read as follows: `rdy` 0, `done` 0, `mem_we` 0, `overflow` all 0, and the ACK flag reads back as 1. Every input queue is empty and every mailbox register is 0.
- R2: A write with `reg_wr_sel` = 0 sets the source tile, 1 sets the start address, 2 sets the word count and starts a message, and 3 sets ACK from data bit 0. The readback port uses the same codes for the first two. Code 2 reads the words still to transfer. Code 3 reads a status word: bit 0 is ACK, bit 1 is RDY, bit 2 is busy, and bits 3 upward hold one overflow bit per source.
- R3: Each flit is queued under its `flit_src`. A message delivers the words of the selected source in arrival order and leaves the other sources' queues untouched.
- R4: In the cycle after the engine first sees ACK at 0 with a non-empty selected queue, it raises `rdy` and pulses `mem_we` for one cycle. In that same cycle `mem_addr` carries the current address and `mem_wdata` carries the oldest queued word.
- R5: In the cycle after the engine sees ACK at 1 while `rdy` is high, `rdy` falls and the remaining count drops by one. The address then advances by one for each word.
- R6: If the selected queue is empty when ACK goes low, `rdy` stays 0. In the cycle after a word for that source is stored, the engine delivers it.
- R7: A flit for a full queue (16 words by default) is dropped and leaves the stored words unchanged. It sets that source's `overflow` bit, which only reset clears.
- R8: `done` is high for exactly one cycle, on the same edge where `rdy` falls for the last word. Afterwards the engine is idle, and ACK changes cause no `rdy` and no `mem_we` until a new count is written.
- R9: A count write while a message is in progress is ignored. A count of zero does not start a message.
- R10: Once `rdy` is high, it stays high for as long as ACK stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flit_valid | input | 1 | Router delivers a flit this cycle |
| flit_src | input | SRC_W | Source tile of the flit |
| flit_data | input | DATA_W | Flit payload word |
| reg_wr_en | input | 1 | Mailbox register write strobe |
| reg_wr_sel | input | 2 | Register code for the write |
| reg_wr_data | input | DATA_W | Write data |
| reg_rd_sel | input | 2 | Register code for the readback |
| reg_rd_data | output | DATA_W | Readback data (combinational) |
| mem_we | output | 1 | Shared-memory write strobe |
| mem_addr | output | ADDR_W | Shared-memory word address |
| mem_wdata | output | DATA_W | Shared-memory write data |
| rdy | output | 1 | RDY flag of the handshake |
| done | output | 1 | One-cycle end-of-message strobe |
| overflow | output | NUM_SRC | Sticky per-source drop flags |

## Verification
The properties assume the processor keeps to the handshake. It lowers ACK only while RDY is low, raises it only after seeing RDY high, and leaves the source, address and count alone while it waits on RDY. The bench drives the processor side only through tasks that wait for each RDY edge before touching ACK. It sends flits only between handshake steps, and it fills a queue past its depth only while no message is draining it. Under these conditions the queue contents in the bench model stay exact.

// File: rtl/mbox_rx_pkg.sv
package mbox_rx_pkg;
   localparam logic [1:0] SEL_SRC   = 2'd0;
   localparam logic [1:0] SEL_ADDR  = 2'd1;
   localparam logic [1:0] SEL_COUNT = 2'd2;
   localparam logic [1:0] SEL_ACK   = 2'd3;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ARM  = 2'd1,
      ST_HOLD = 2'd2
   } rx_state_e;
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] head,
   output logic              empty,
   output logic              full
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam logic [PTR_W:0] FULL_CNT = (PTR_W+1)'(DEPTH);

   logic [DATA_W-1:0] store [DEPTH];
   logic [PTR_W-1:0]  wptr, rptr;
   logic [PTR_W:0]    level;
   logic              push_ok, pop_ok;

   assign empty   = (level == '0);
   assign full    = (level == FULL_CNT);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign head    = store[rptr];

   always_ff @(posedge clk) begin
      if (rst) begin
         wptr  <= '0;
         rptr  <= '0;
         level <= '0;
      end else begin
         if (push_ok) wptr <= wptr + 1'b1;
         if (pop_ok)  rptr <= rptr + 1'b1;
         level <= level + {{PTR_W{1'b0}}, push_ok} - {{PTR_W{1'b0}}, pop_ok};
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) store[wptr] <= push_data;
   end
endmodule

// File: rtl/mbox_rx_inbuf.sv
module mbox_rx_inbuf #(
   parameter int NUM_SRC = 4,
   parameter int DEPTH   = 16,
   parameter int DATA_W  = 32,
   localparam int SRC_W  = $clog2(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               flit_valid,
   input  logic [SRC_W-1:0]   flit_src,
   input  logic [DATA_W-1:0]  flit_data,
   input  logic [SRC_W-1:0]   sel,
   input  logic               pop,
   output logic [DATA_W-1:0]  head,
   output logic               empty,
   output logic [NUM_SRC-1:0] overflow
);
   logic [DATA_W-1:0]  heads [NUM_SRC];
   logic [NUM_SRC-1:0] empties;
   logic [NUM_SRC-1:0] fulls;

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      logic hit;
      assign hit = flit_valid && (flit_src == SRC_W'(g));

      mbox_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_fifo (
         .clk       (clk),
         .rst       (rst),
         .push      (hit),
         .push_data (flit_data),
         .pop       (pop && (sel == SRC_W'(g))),
         .head      (heads[g]),
         .empty     (empties[g]),
         .full      (fulls[g])
      );

      always_ff @(posedge clk) begin
         if (rst)                overflow[g] <= 1'b0;
         else if (hit && fulls[g]) overflow[g] <= 1'b1;
      end
   end

   assign head  = heads[sel];
   assign empty = empties[sel];
endmodule

// File: rtl/mbox_rx_ctrl.sv
module mbox_rx_ctrl
   import mbox_rx_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 8,
   parameter int SRC_W  = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [CNT_W-1:0]  cfg_cnt,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [SRC_W-1:0]  cfg_src,
   input  logic              ack,
   input  logic              fifo_empty,
   input  logic [DATA_W-1:0] fifo_head,
   output logic [SRC_W-1:0]  sel,
   output logic              pop,
   output logic              rdy,
   output logic              done,
   output logic              busy,
   output logic [CNT_W-1:0]  remaining,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata
);
   rx_state_e         state;
   logic [ADDR_W-1:0] cur_addr;

   assign busy = (state != ST_IDLE);
   assign pop  = (state == ST_ARM) && !ack && !fifo_empty;

   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= ST_IDLE;
         sel       <= '0;
         cur_addr  <= '0;
         remaining <= '0;
         rdy       <= 1'b0;
         done      <= 1'b0;
         mem_we    <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
      end else begin
         mem_we <= 1'b0;
         done   <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start && (cfg_cnt != '0)) begin
                  remaining <= cfg_cnt;
                  cur_addr  <= cfg_addr;
                  sel       <= cfg_src;
                  state     <= ST_ARM;
               end
            end
            ST_ARM: begin
               if (pop) begin
                  mem_we    <= 1'b1;
                  mem_addr  <= cur_addr;
                  mem_wdata <= fifo_head;
                  cur_addr  <= cur_addr + 1'b1;
                  rdy       <= 1'b1;
                  state     <= ST_HOLD;
               end
            end
            ST_HOLD: begin
               if (ack) begin
                  rdy       <= 1'b0;
                  remaining <= remaining - 1'b1;
                  if (remaining == CNT_W'(1)) begin
                     done  <= 1'b1;
                     state <= ST_IDLE;
                  end else begin
                     state <= ST_ARM;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/mbox_rx_engine.sv
module mbox_rx_engine
   import mbox_rx_pkg::*;
#(
   parameter int NUM_SRC = 4,
   parameter int DEPTH   = 16,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 16,
   parameter int CNT_W   = 8,
   localparam int SRC_W  = $clog2(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               flit_valid,
   input  logic [SRC_W-1:0]   flit_src,
   input  logic [DATA_W-1:0]  flit_data,
   input  logic               reg_wr_en,
   input  logic [1:0]         reg_wr_sel,
   input  logic [DATA_W-1:0]  reg_wr_data,
   input  logic [1:0]         reg_rd_sel,
   output logic [DATA_W-1:0]  reg_rd_data,
   output logic               mem_we,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [DATA_W-1:0]  mem_wdata,
   output logic               rdy,
   output logic               done,
   output logic [NUM_SRC-1:0] overflow
);
   localparam int STAT_W = 3 + NUM_SRC;

   if (NUM_SRC < 2 || (NUM_SRC & (NUM_SRC - 1)) != 0) begin : g_bad_src
      $error("NUM_SRC must be a power of two, at least 2");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 2");
   end
   if (DATA_W < ADDR_W || DATA_W < CNT_W || DATA_W < STAT_W) begin : g_bad_width
      $error("DATA_W too narrow for mailbox readback");
   end

   logic [SRC_W-1:0]  cfg_src;
   logic [ADDR_W-1:0] cfg_addr;
   logic [CNT_W-1:0]  cfg_cnt;
   logic              ack_q;
   logic              start;
   logic [SRC_W-1:0]  sel_w;
   logic              pop_w, empty_w, busy_w;
   logic [DATA_W-1:0] head_w;
   logic [CNT_W-1:0]  remaining_w;

   assign start = reg_wr_en && (reg_wr_sel == SEL_COUNT);

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg_src  <= '0;
         cfg_addr <= '0;
         cfg_cnt  <= '0;
         ack_q    <= 1'b1;
      end else if (reg_wr_en) begin
         unique case (reg_wr_sel)
            SEL_SRC:   cfg_src  <= reg_wr_data[SRC_W-1:0];
            SEL_ADDR:  cfg_addr <= reg_wr_data[ADDR_W-1:0];
            SEL_COUNT: cfg_cnt  <= reg_wr_data[CNT_W-1:0];
            SEL_ACK:   ack_q    <= reg_wr_data[0];
            default: ;
         endcase
      end
   end

   always_comb begin
      unique case (reg_rd_sel)
         SEL_SRC:   reg_rd_data = DATA_W'(cfg_src);
         SEL_ADDR:  reg_rd_data = DATA_W'(cfg_addr);
         SEL_COUNT: reg_rd_data = DATA_W'(remaining_w);
         default:   reg_rd_data = DATA_W'({overflow, busy_w, rdy, ack_q});
      endcase
   end

   mbox_rx_inbuf #(.NUM_SRC(NUM_SRC), .DEPTH(DEPTH), .DATA_W(DATA_W)) i_inbuf (
      .clk        (clk),
      .rst        (rst),
      .flit_valid (flit_valid),
      .flit_src   (flit_src),
      .flit_data  (flit_data),
      .sel        (sel_w),
      .pop        (pop_w),
      .head       (head_w),
      .empty      (empty_w),
      .overflow   (overflow)
   );

   mbox_rx_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SRC_W(SRC_W)) i_ctrl (
      .clk        (clk),
      .rst        (rst),
      .start      (start),
      .cfg_cnt    (reg_wr_data[CNT_W-1:0]),
      .cfg_addr   (cfg_addr),
      .cfg_src    (cfg_src),
      .ack        (ack_q),
      .fifo_empty (empty_w),
      .fifo_head  (head_w),
      .sel        (sel_w),
      .pop        (pop_w),
      .rdy        (rdy),
      .done       (done),
      .busy       (busy_w),
      .remaining  (remaining_w),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata)
   );
endmodule

// File: rtl/mbox_rx_chk.sv
module mbox_rx_chk #(
   parameter int NUM_SRC = 4
) (
   input logic               clk,
   input logic               rst,
   input logic               ack,
   input logic               rdy,
   input logic               done,
   input logic               mem_we,
   input logic               busy,
   input logic [NUM_SRC-1:0] overflow
);
   AST_RDY_AFTER_ACK_LOW: assert property (@(posedge clk) disable iff (rst)
      $rose(rdy) |-> !$past(ack)); // R4
   AST_WE_ON_RDY_RISE: assert property (@(posedge clk) disable iff (rst)
      mem_we |-> $rose(rdy)); // R4
   AST_RDY_FALL_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
      $fell(rdy) |-> $past(ack)); // R5
   AST_RDY_HOLD: assert property (@(posedge clk) disable iff (rst)
      (rdy && !ack) |=> rdy); // R10
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      done |=> !done); // R8
   AST_DONE_WITH_FALL: assert property (@(posedge clk) disable iff (rst)
      done |-> $fell(rdy)); // R8
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
      !busy |-> !rdy); // R8
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
      (|overflow) |=> ((overflow & $past(overflow)) == $past(overflow))); // R7
endmodule

bind mbox_rx_engine mbox_rx_chk #(.NUM_SRC(NUM_SRC)) i_chk (
   .clk      (clk),
   .rst      (rst),
   .ack      (ack_q),
   .rdy      (rdy),
   .done     (done),
   .mem_we   (mem_we),
   .busy     (busy_w),
   .overflow (overflow)
);

// File: tb/test_mbox_rx_engine.sv
`timescale 1ns/1ps
module test_mbox_rx_engine;
   localparam int NS = 4, DW = 32, AW = 16;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          flit_valid = 1'b0;
   logic [1:0]    flit_src = '0;
   logic [DW-1:0] flit_data = '0;
   logic          reg_wr_en = 1'b0;
   logic [1:0]    reg_wr_sel = '0;
   logic [DW-1:0] reg_wr_data = '0;
   logic [1:0]    reg_rd_sel = '0;
   logic [DW-1:0] reg_rd_data;
   logic          mem_we, rdy, done;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [NS-1:0] overflow;

   int n_chk = 0, n_fail = 0;
   logic [DW-1:0] model [NS][$];
   logic [DW-1:0] exp_data [$];
   logic [AW-1:0] exp_addr [$];

   always #2.5 clk = ~clk;

   mbox_rx_engine i_mbox_rx_engine (
      .clk(clk), .rst(rst), .flit_valid(flit_valid), .flit_src(flit_src),
      .flit_data(flit_data), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
      .reg_wr_data(reg_wr_data), .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .rdy(rdy), .done(done), .overflow(overflow));

   task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // scoreboard monitor: every shared-memory write must match the head of the queue
   always @(negedge clk) begin
      if (!rst && mem_we) begin
         if (exp_data.size() == 0) begin
            chk(1'b0, "R8 unexpected mem write", DW'(mem_addr), '0);
         end else begin
            logic [DW-1:0] ed;
            logic [AW-1:0] ea;
            ed = exp_data.pop_front();
            ea = exp_addr.pop_front();
            chk(mem_wdata == ed, "R3 data order", mem_wdata, ed);
            chk(mem_addr == ea, "R5 address step", DW'(mem_addr), DW'(ea));
         end
      end
   end

   task automatic wr(input logic [1:0] sel, input logic [DW-1:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] sel, output logic [DW-1:0] v);
      reg_rd_sel = sel;
      #0.2;
      v = reg_rd_data;
   endtask

   task automatic send_flit(input logic [1:0] s, input logic [DW-1:0] d);
      @(negedge clk);
      flit_valid = 1'b1; flit_src = s; flit_data = d;
      if (model[s].size() < 16) model[s].push_back(d);
      @(negedge clk);
      flit_valid = 1'b0;
   endtask

   task automatic xfer_word(input bit last);
      wr(2'd3, 0);
      @(negedge clk);
      chk(rdy == 1'b1, "R4 rdy after ack low", DW'(rdy), 1);
      wr(2'd3, 1);
      @(negedge clk);
      chk(rdy == 1'b0, "R5 rdy after ack high", DW'(rdy), 0);
      chk(done == last, "R8 done on last word", DW'(done), DW'(last));
      if (last) begin
         @(negedge clk);
         chk(done == 1'b0, "R8 done single cycle", DW'(done), 0);
      end
   endtask

   task automatic run_msg(input logic [1:0] s, input logic [AW-1:0] a, input int n);
      logic [DW-1:0] v;
      wr(2'd0, DW'(s));
      wr(2'd1, DW'(a));
      for (int i = 0; i < n; i++) begin
         exp_data.push_back(model[s].pop_front());
         exp_addr.push_back(a + AW'(i));
      end
      wr(2'd2, DW'(n));
      rd(2'd2, v);
      chk(v == DW'(n), "R2 remaining readback", v, DW'(n));
      for (int i = 0; i < n; i++) xfer_word(i == n - 1);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #500000;
      chk(1'b0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      logic [DW-1:0] v;
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk(rdy == 0 && done == 0 && mem_we == 0, "R1 outputs idle", DW'({rdy, done, mem_we}), 0);
      chk(overflow == '0, "R1 overflow clear", DW'(overflow), 0);
      rd(2'd3, v);
      chk(v == DW'(1), "R1 status ack=1", v, 1);
      rd(2'd1, v);
      chk(v == 0, "R1 address register clear", v, 0);

      // R2 register codes
      wr(2'd0, 2); wr(2'd1, 16'h0123);
      rd(2'd0, v); chk(v == 2, "R2 source readback", v, 2);
      rd(2'd1, v); chk(v == 16'h0123, "R2 address readback", v, 16'h0123);

      // R3/R4/R5: interleaved sources, deliver source 2 then source 1
      send_flit(1, 32'hA1); send_flit(2, 32'hB1); send_flit(1, 32'hA2);
      send_flit(2, 32'hB2); send_flit(2, 32'hB3);
      run_msg(2, 16'h0100, 3);
      run_msg(1, 16'h0200, 2);
      chk(exp_data.size() == 0, "R3 all words written", DW'(exp_data.size()), 0);

      // R8: idle ack toggles produce nothing
      wr(2'd3, 0);
      repeat (3) begin
         @(negedge clk);
         chk(rdy == 0, "R8 idle rdy stays low", DW'(rdy), 0);
      end
      wr(2'd3, 1);

      // R9: zero count does not start
      wr(2'd2, 0);
      rd(2'd3, v);
      chk(v[2] == 0, "R9 zero count not busy", DW'(v[2]), 0);

      // R6: empty queue wait, then R9: count rewrite while busy ignored
      wr(2'd0, 0); wr(2'd1, 16'h0300);
      wr(2'd2, 2);
      wr(2'd2, 7);
      rd(2'd2, v);
      chk(v == 2, "R9 busy count write ignored", v, 2);
      wr(2'd3, 0);
      repeat (4) begin
         @(negedge clk);
         chk(rdy == 0, "R6 rdy low while empty", DW'(rdy), 0);
      end
      exp_data.push_back(32'hC1); exp_addr.push_back(16'h0300);
      send_flit(0, 32'hC1);
      void'(model[0].pop_front());
      @(negedge clk);
      chk(rdy == 1, "R6 delivery after arrival", DW'(rdy), 1);
      wr(2'd3, 1);
      @(negedge clk);
      chk(rdy == 0 && done == 0, "R5 first word closed", DW'({rdy, done}), 0);
      send_flit(0, 32'hC2);
      exp_data.push_back(model[0].pop_front()); exp_addr.push_back(16'h0301);
      xfer_word(1'b1);

      // R7: overflow on source 3
      for (int i = 0; i < 17; i++) send_flit(3, 32'hD00 + DW'(i));
      @(negedge clk);
      chk(overflow == 4'b1000, "R7 overflow bit for source 3", DW'(overflow), 4'b1000);
      rd(2'd3, v);
      chk(v[6:3] == 4'b1000, "R2 status overflow field", DW'(v[6:3]), 4'b1000);
      run_msg(3, 16'h0400, 16);
      chk(overflow == 4'b1000, "R7 overflow sticky", DW'(overflow), 4'b1000);
      repeat (3) @(negedge clk);
      chk(exp_data.size() == 0, "R7 first sixteen kept", DW'(exp_data.size()), 0);
      finish_run();
   end
endmodule